// File: doc/BRIEF.md
# Audio Noise Gate Controller

The block watches a signed audio sample stream that has already been scaled by the user volume. When that signal stays quiet for long enough, it fades the output toward mute. It produces an effective attenuation code from an attenuation register of its own, kept apart from the user volume code. The user volume code enters as an input and the block never writes it back, so whatever software reads from that setting stays as programmed. A larger code means more attenuation, and the all-ones code is mute.

The block acts only on sample-enable ticks. It compares the magnitude of each sample against a threshold and counts how many quiet ticks arrive in a row. After the programmed number of quiet ticks the gate engages, and the attenuation then rises one code per attack period. The first sample at or above the threshold turns the block into release. Release lowers the attenuation one code per release period until it reaches the user code, and it can begin in the middle of an attack. The threshold, hold, attack and release settings are captured while the gate is disabled and stay frozen while it is enabled.

Top module: `noise_gate`

## Requirements
- R1: The loudness of a sample is its two's-complement magnitude. A magnitude equal to or above the threshold counts as loud, and the most negative code counts with its full magnitude.
- R2: The gate engages, with `gate_engaged` going high, on the tick that completes `hold_cfg` consecutive quiet ticks, and not earlier.
- R3: Every loud tick clears the quiet run, so the hold count starts again from zero.
- R4: While the gate is engaged, the attenuation rises by exactly one code every `attack_cfg`+1 ticks. The first step comes `attack_cfg`+1 ticks after the engaging tick, and the attenuation stops at the all-ones mute code.
- R5: A loud tick ends the attack at once, even partway through, and starts a release from the current attenuation. In release the attenuation falls by one code every `release_cfg`+1 ticks until it equals `user_vol`.
- R6: `eff_atten` is never below `user_vol`. A raised `user_vol` shows on `eff_atten` in the same cycle.
- R7: While `enable` is high, `eff_atten` changes only on cycles with `sample_en` high, unless `user_vol` itself changes.
- R8: The threshold, hold, attack and release settings are captured while `enable` is low. Changing these settings while `enable` is high has no effect.
- R9: While `enable` is low, `eff_atten` equals `user_vol` and the gate state is cleared. After re-enabling, a full hold period is needed before the gate engages.
- R10: After reset, `eff_atten` equals `user_vol` and `gate_engaged` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gate on; settings are captured while low |
| sample_en | input | 1 | One-cycle tick marking a valid sample |
| sample | input | W | Signed sample after user volume scaling |
| threshold | input | W | Magnitude threshold |
| hold_cfg | input | HW | Quiet ticks needed to engage |
| attack_cfg | input | RW | Attack step period minus one, in ticks |
| release_cfg | input | RW | Release step period minus one, in ticks |
| user_vol | input | AW | User attenuation code |
| eff_atten | output | AW | Applied attenuation code |
| gate_engaged | output | 1 | High while the gate is attenuating |

## Verification
The stimulus first uses a run of steady quiet samples, which separates the hold qualification from the attack pacing and also drives the attenuation to the mute ceiling. Quiet runs broken by a single loud sample show whether the hold count restarts. A loud sample placed partway through an attack shows whether release begins from the current code. Samples at exactly the threshold, at the threshold negated, just below it and at the most negative code separate a `>=` comparison from a `>` comparison, and a correct magnitude from a wrong one. Changing the settings or the user code while the gate is active shows which inputs are frozen and which pass straight through.

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int W  = 16,
  parameter int AW = 6,
  parameter int HW = 12,
  parameter int RW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                sample_en,
  input  logic signed [W-1:0] sample,
  input  logic [W-1:0]        threshold,
  input  logic [HW-1:0]       hold_cfg,
  input  logic [RW-1:0]       attack_cfg,
  input  logic [RW-1:0]       release_cfg,
  input  logic [AW-1:0]       user_vol,
  output logic [AW-1:0]       eff_atten,
  output logic                gate_engaged
);
  logic [W-1:0]  thr_l;
  logic [HW-1:0] hold_l, qcnt, qnext;
  logic [RW-1:0] atk_l, rel_l, rcnt, period;
  logic [AW-1:0] g, g_base, g_up;
  logic          dir, loud, eng, fire;
  logic signed [W:0] sx;
  logic [W:0]    mag;

  assign sx     = {sample[W-1], sample};
  assign mag    = sample[W-1] ? -sx : sx;
  assign loud   = mag >= {1'b0, thr_l};
  assign qnext  = loud ? '0 : (qcnt == hold_l ? qcnt : qcnt + 1'b1);
  assign eng    = !loud && (qnext == hold_l);
  assign period = eng ? atk_l : rel_l;
  assign fire   = (eng == dir) && (rcnt == period);
  assign g_base = (g > user_vol) ? g : user_vol;
  assign g_up   = (&g_base) ? g_base : g_base + 1'b1;

  assign eff_atten    = (g > user_vol) ? g : user_vol;
  assign gate_engaged = dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_l  <= '0;
      hold_l <= '0;
      atk_l  <= '0;
      rel_l  <= '0;
      qcnt   <= '0;
      rcnt   <= '0;
      dir    <= 1'b0;
      g      <= '0;
    end else if (!enable) begin
      thr_l  <= threshold;
      hold_l <= hold_cfg;
      atk_l  <= attack_cfg;
      rel_l  <= release_cfg;
      qcnt   <= '0;
      rcnt   <= '0;
      dir    <= 1'b0;
      g      <= user_vol;
    end else if (sample_en) begin
      qcnt <= qnext;
      dir  <= eng;
      if (eng != dir)          rcnt <= '0;
      else if (rcnt == period) rcnt <= '0;
      else                     rcnt <= rcnt + 1'b1;
      if (!eng && g <= user_vol) g <= user_vol;
      else if (fire)             g <= eng ? g_up : g - 1'b1;
    end
  end
endmodule

module noise_gate_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          sample_en,
  input logic [AW-1:0] user_vol,
  input logic [AW-1:0] eff_atten,
  input logic          gate_engaged
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !sample_en |=> (user_vol != $past(user_vol)) || $stable(eff_atten)); // R7

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    enable && sample_en |=> (user_vol != $past(user_vol)) || $stable(eff_atten) ||
      (eff_atten == $past(eff_atten) + 1'b1) || (eff_atten == $past(eff_atten) - 1'b1)); // R4

  AST_RELEASE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    enable && sample_en |=> gate_engaged || (user_vol != $past(user_vol)) ||
      (eff_atten <= $past(eff_atten))); // R5

  AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (user_vol != $past(user_vol)) || (eff_atten == user_vol)); // R9

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_engaged); // R9
endmodule

bind noise_gate noise_gate_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sample_en(sample_en),
  .user_vol(user_vol), .eff_atten(eff_atten), .gate_engaged(gate_engaged)
);

// File: tb/noise_gate_test.sv
module noise_gate_test;
  localparam int W = 8, AW = 4, HW = 4, RW = 3;

  logic clk = 0, rst_n = 0, enable = 0, sample_en = 0;
  logic signed [W-1:0] sample = 0;
  logic [W-1:0]  threshold = 20;
  logic [HW-1:0] hold_cfg = 3;
  logic [RW-1:0] attack_cfg = 1, release_cfg = 0;
  logic [AW-1:0] user_vol = 2, eff_atten;
  logic          gate_engaged;

  int tests = 0, fails = 0;
  int m_thr, m_hold, m_atk, m_rel, m_q, m_since, m_g;
  bit m_dir;
  int exp_q[$];
  string tag_q[$];

  noise_gate #(.W(W), .AW(AW), .HW(HW), .RW(RW)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(int got, int exp, string tag);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic capture_model();
    m_thr = threshold; m_hold = hold_cfg; m_atk = attack_cfg; m_rel = release_cfg;
    m_q = 0; m_since = 0; m_dir = 0; m_g = user_vol;
  endtask

  task automatic model_tick(int s);
    int mag, per, top;
    bit loud, e, step;
    mag  = (s < 0) ? -s : s;
    loud = mag >= m_thr;
    if (loud) m_q = 0;
    else if (m_q < m_hold) m_q++;
    e = !loud && (m_q == m_hold);
    step = 0;
    if (e != m_dir) begin m_dir = e; m_since = 0; end
    else begin
      per = e ? m_atk : m_rel;
      if (m_since == per) begin m_since = 0; step = 1; end
      else m_since++;
    end
    if (!e && m_g <= user_vol) m_g = user_vol;
    else if (step) begin
      if (e) begin
        top = (m_g > user_vol) ? m_g : user_vol;
        m_g = (top >= 15) ? 15 : top + 1;
      end else m_g--;
    end
  endtask

  function automatic int model_eff();
    return (m_g > user_vol) ? m_g : user_vol;
  endfunction

  task automatic tick(int s, string tag);
    @(negedge clk);
    sample = s[W-1:0];
    sample_en = 1;
    model_tick(s);
    exp_q.push_back(model_eff());
    tag_q.push_back(tag);
    @(negedge clk);
    sample_en = 0;
  endtask

  always @(posedge clk) begin
    if (sample_en && enable) begin
      #1;
      if (exp_q.size() == 0) chk(-1, 0, "queue empty");
      else chk(int'(eff_atten), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic disable_and_load();
    @(negedge clk); enable = 0;
    repeat (2) @(negedge clk);
    capture_model();
    enable = 1;
  endtask

  initial begin
    #(4 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(eff_atten, 2, "R10 reset atten");
    chk(gate_engaged, 0, "R10 reset engaged");
    disable_and_load();

    tick(5, "R2 quiet1"); tick(5, "R2 quiet2");
    chk(gate_engaged, 0, "R2 not yet engaged");
    tick(-5, "R2 engage");
    chk(gate_engaged, 1, "R2 engaged");
    for (int i = 0; i < 4; i++) tick(3, "R4 attack step");
    repeat (3) @(negedge clk);
    chk(eff_atten, model_eff(), "R7 idle stable");
    tick(-30, "R5 release start");
    chk(gate_engaged, 0, "R5 released");
    for (int i = 0; i < 4; i++) tick(25, "R5 release step");

    tick(1, "R3 q1"); tick(1, "R3 q2"); tick(40, "R3 loud");
    tick(1, "R3 q1b"); tick(1, "R3 q2b");
    chk(gate_engaged, 0, "R3 hold restarted");

    for (int i = 0; i < 40; i++) tick(0, "R4 to mute");
    chk(eff_atten, 15, "R4 saturate");

    tick(20, "R1 equal is loud");
    chk(gate_engaged, 0, "R1 equal loud");
    for (int i = 0; i < 5; i++) tick(19, "R1 below is quiet");
    chk(gate_engaged, 1, "R1 19 quiet");
    tick(-20, "R1 neg equal loud");
    chk(gate_engaged, 0, "R1 -20 loud");
    for (int i = 0; i < 5; i++) tick(-19, "R1 neg quiet");
    tick(-128, "R1 most negative");
    chk(gate_engaged, 0, "R1 -128 loud");

    for (int i = 0; i < 20; i++) tick(2, "R5 refill");
    for (int i = 0; i < 4; i++) tick(-2, "R5 attack");
    tick(100, "R5 mid attack release");
    for (int i = 0; i < 3; i++) tick(100, "R5 mid release");

    @(negedge clk); user_vol = 13;
    #1 chk(eff_atten, model_eff(), "R6 raise immediate");
    chk(int'(eff_atten >= user_vol), 1, "R6 floor");
    tick(100, "R6 track user");
    @(negedge clk); user_vol = 2;

    threshold = 0; hold_cfg = 0; attack_cfg = 7;
    for (int i = 0; i < 8; i++) tick(4, "R8 frozen settings");
    chk(gate_engaged, 1, "R8 old threshold used");

    @(negedge clk); enable = 0;
    @(negedge clk); #1;
    chk(eff_atten, user_vol, "R9 disabled follows user");
    chk(gate_engaged, 0, "R9 disabled cleared");
    threshold = 20; hold_cfg = 3; attack_cfg = 1;
    @(negedge clk);
    capture_model();
    enable = 1;
    tick(1, "R9 fresh q1"); tick(1, "R9 fresh q2");
    chk(gate_engaged, 0, "R9 full hold needed");
    tick(1, "R9 fresh q3");
    chk(gate_engaged, 1, "R9 engaged after hold");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "queue drained");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule